// File: doc/BRIEF.md
# Serial control register interface with startup interlock

This block is the control front end of a video decoder and sync processor. It is a byte-level slave on a two-wire serial control bus. It detects start and stop conditions and matches the device address. It acknowledges bytes, takes in write data and shifts out read data. Four write registers hold the decoder's configuration. The register bits leave the block as decoded fields, so the analog and timing blocks can use them directly. A read of the device always returns one status byte. The status byte is built from status inputs supplied by the other blocks, together with the block's own power-on flag.

A write transaction starts with a subaddress byte and may then carry any number of data bytes. Subaddress 00 configures input selection, the chroma trap bypass, comb filter enable, the first-loop time constant and the crystal fit. Subaddress 01 holds the field-rate force, the two general-purpose port levels, the first-loop open control and the forced-standard code. Subaddress 02 holds the fast-switch and search-tuning enables and a 6-bit hue code. Subaddress 03 holds the line-locked clock enable. The subaddress pointer advances after each data byte. A strap input moves the device between two addresses.

After reset, a power-on flag is raised and the line-oscillator calibration request is held back. The request is released only by a write to subaddress 01 that comes after a write to subaddress 00. That write clears the flag and starts a calibration. Once started, the calibration request stays high until a done input reports that the target frequency has been reached. After startup, a loss-of-lock report raises the request again.

Top module: `vdec_ctrl_if`

## Requirements
- R1: A synchronous active-high `rst` clears every decoded field to zero, sets `por_flag` to 1, clears `cal_req` and releases `sda_pull`.
- R2: The slave acknowledges the 7-bit address 1000101 when `addr_sel` is 0 and 1000111 when `addr_sel` is 1. The address is followed by a read/write bit, with 1 meaning read. A transaction to any other address gets no acknowledge, and none of its bytes change any field.
- R3: The first data byte of a write sets the subaddress pointer from its low 4 bits. The pointer increments by one after each following data byte and wraps from 0F to 00. Every byte of an addressed write is acknowledged.
- R4: Written bytes land in fields as follows. Subaddress 00: `src_sel` = bits 7:6, `trap_bypass` = bit 5, `comb_en` = bit 4, `ph1_tc` = bits 3:2, `xtal_cfg` = bits 1:0. Subaddress 01: `field_force` = bits 7:6, `port_a` = bit 5, `port_b` = bit 4, `ph1_open` = bit 3, `std_force` = bits 2:0. Subaddress 02: `fast_sw_en` = bit 7, `search_tune` = bit 6, `hue_code` = bits 5:0. Subaddress 03: `llc_en` = bit 7. A field changes only when its register is written.
- R5: Data bytes written to subaddresses 04 to 0F are acknowledged and change no field.
- R6: A read returns the status byte, whatever the pointer holds. The byte is {`por_flag`, `st_field60`, `st_yc_mode`, `st_locked`, `st_port_in`, `st_std[2:0]`}, sent MSB first. It is repeated for every byte that the master acknowledges.
- R7: A write to subaddress 01 clears `por_flag` and raises `cal_req`, but only when a write to subaddress 00 has occurred since reset. A write to 01 before any write to 00 changes neither.
- R8: Once `por_flag` is 0, a `lock_lost` pulse raises `cal_req`. While `por_flag` is 1, `lock_lost` is ignored.
- R9: `cal_done` clears `cal_req` on the next clock, unless a new request arrives in the same cycle.
- R10: `hue_step` is the signed value 2*`hue_code` - 63. This gives -63 for code 000000 and +63 for code 111111.
- R11: Once cleared, `por_flag` returns to 1 only through `rst`. Writes to 00 and 01 after startup do not raise `cal_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Address strap; 1 selects the alternate device address |
| sda_pull | output | 1 | 1 pulls the data line low |
| st_field60 | input | 1 | Status: 60 Hz field rate found |
| st_yc_mode | input | 1 | Status: input switch state |
| st_locked | input | 1 | Status: first loop locked |
| st_port_in | input | 1 | Status: general-purpose port pin level |
| st_std | input | 3 | Status: identified standard code |
| lock_lost | input | 1 | Coincidence detector reports loss of lock |
| cal_done | input | 1 | Oscillator calibration reached target |
| src_sel | output | 2 | Input source select |
| trap_bypass | output | 1 | Chroma trap bypass |
| comb_en | output | 1 | Comb filter enable |
| ph1_tc | output | 2 | First-loop time constant mode |
| xtal_cfg | output | 2 | Crystal fit indication |
| field_force | output | 2 | Field-rate force mode |
| port_a | output | 1 | Open-drain port level |
| port_b | output | 1 | Output port level |
| ph1_open | output | 1 | First loop opened |
| std_force | output | 3 | Forced-standard code |
| fast_sw_en | output | 1 | Fast switch enable |
| search_tune | output | 1 | Search tuning mode |
| hue_code | output | 6 | Raw hue code |
| hue_step | output | 8 | Signed hue offset in steps of 45/63 degree |
| llc_en | output | 1 | Line-locked clock mode |
| por_flag | output | 1 | Power-on flag |
| cal_req | output | 1 | Line-oscillator calibration request |

## Verification
A corrupted subaddress pointer shows on the decoded field outputs just after the stop of the write that used it. A lost write to 00 instead leaves `por_flag` high and `cal_req` low right after the following write to 01. A wrong bus state machine shows within one bit time as a missing or misplaced acknowledge, or as a shifted status byte on the data line. A stale calibration flag is visible on `cal_req` one clock after `cal_done` or `lock_lost`.

// File: rtl/vdec_ctrl_pkg.sv
package vdec_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK_TX,
      PH_TX,
      PH_ACK_RX,
      PH_SKIP
   } phy_state_t;

   typedef struct packed {
      logic [1:0] src_sel;
      logic       trap_bypass;
      logic       comb_en;
      logic [1:0] ph1_tc;
      logic [1:0] xtal_cfg;
      logic [1:0] field_force;
      logic       port_a;
      logic       port_b;
      logic       ph1_open;
      logic [2:0] std_force;
      logic       fast_sw_en;
      logic       search_tune;
      logic [5:0] hue;
      logic       llc_en;
   } ctrl_fields_t;

   localparam int BYTE_W   = 8;
   localparam int BIT_CNT_W = 4;

endpackage

// File: rtl/vdec_ctrl_phy.sv
module vdec_ctrl_phy
   import vdec_ctrl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] BASE_ADDR   = 7'b1000101,
   parameter int         SEL_BIT     = 1,
   parameter bit         ADDR_SEL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_pull,
   output logic              scl_s,
   output logic              byte_stb,
   output logic              byte_first,
   output logic [BYTE_W-1:0] byte_data
);

   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $fatal(1, "SYNC_STAGES out of range");
      if (SEL_BIT < 0 || SEL_BIT > 6)
         $fatal(1, "SEL_BIT out of range");
   end

   logic sda_s;

   // input synchronizer variant
   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_i;
      assign sda_s = sda_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
         end else begin
            scl_q <= (scl_q << 1) | SYNC_STAGES'(scl_i);
            sda_q <= (sda_q << 1) | SYNC_STAGES'(sda_i);
         end
      end
      assign scl_s = scl_q[SYNC_STAGES-1];
      assign sda_s = sda_q[SYNC_STAGES-1];
   end

   // device address variant
   logic [6:0] dev_addr;
   if (ADDR_SEL_EN) begin : g_strap
      always_comb begin
         dev_addr          = BASE_ADDR;
         dev_addr[SEL_BIT] = addr_sel;
      end
   end else begin : g_fixed
      assign dev_addr = BASE_ADDR;
   end

   logic p_scl, p_sda;
   logic scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_s & ~p_scl;
   assign scl_fall = ~scl_s & p_scl;
   assign start_c  = scl_s & p_scl & p_sda & ~sda_s;
   assign stop_c   = scl_s & p_scl & ~p_sda & sda_s;

   phy_state_t           state;
   logic [BIT_CNT_W-1:0] cnt;
   logic [BYTE_W-1:0]    sh;
   logic                 is_addr, rw, first;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= PH_IDLE;
         cnt        <= '0;
         sh         <= '0;
         is_addr    <= 1'b0;
         rw         <= 1'b0;
         first      <= 1'b0;
         sda_pull   <= 1'b0;
         byte_stb   <= 1'b0;
         byte_first <= 1'b0;
         byte_data  <= '0;
         p_scl      <= 1'b1;
         p_sda      <= 1'b1;
      end else begin
         p_scl    <= scl_s;
         p_sda    <= sda_s;
         byte_stb <= 1'b0;
         if (start_c) begin
            state    <= PH_RX;
            cnt      <= '0;
            is_addr  <= 1'b1;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            state    <= PH_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               PH_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (is_addr) begin
                        is_addr <= 1'b0;
                        if (sh[7:1] == dev_addr) begin
                           rw       <= sh[0];
                           first    <= 1'b1;
                           sda_pull <= 1'b1;
                           state    <= PH_ACK_TX;
                        end else begin
                           state <= PH_SKIP;
                        end
                     end else begin
                        byte_stb   <= 1'b1;
                        byte_first <= first;
                        byte_data  <= sh;
                        first      <= 1'b0;
                        sda_pull   <= 1'b1;
                        state      <= PH_ACK_TX;
                     end
                  end
               end
               PH_ACK_TX: begin
                  if (scl_fall) begin
                     if (rw) begin
                        state    <= PH_TX;
                        sda_pull <= ~rd_byte[BYTE_W-1];
                        sh       <= {rd_byte[BYTE_W-2:0], 1'b0};
                        cnt      <= BIT_CNT_W'(1);
                     end else begin
                        state    <= PH_RX;
                        sda_pull <= 1'b0;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        state    <= PH_ACK_RX;
                     end else begin
                        sda_pull <= ~sh[BYTE_W-1];
                        sh       <= {sh[BYTE_W-2:0], 1'b0};
                        cnt      <= cnt + 1'b1;
                     end
                  end
               end
               PH_ACK_RX: begin
                  if (scl_rise)
                     state <= sda_s ? PH_SKIP : PH_ACK_TX;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/vdec_ctrl_regs.sv
module vdec_ctrl_regs
   import vdec_ctrl_pkg::*;
#(
   parameter int SUB_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_stb,
   input  logic              byte_first,
   input  logic [BYTE_W-1:0] byte_data,
   output ctrl_fields_t      fields,
   output logic              wr_stb,
   output logic [SUB_W-1:0]  wr_idx
);

   initial begin
      if (SUB_W < 2 || SUB_W > BYTE_W)
         $fatal(1, "SUB_W out of range");
   end

   logic [SUB_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr    <= '0;
         fields <= '0;
         wr_stb <= 1'b0;
         wr_idx <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (byte_stb) begin
            if (byte_first) begin
               ptr <= byte_data[SUB_W-1:0];
            end else begin
               wr_stb <= 1'b1;
               wr_idx <= ptr;
               ptr    <= ptr + 1'b1;
               case (ptr)
                  SUB_W'(0): begin
                     fields.src_sel     <= byte_data[7:6];
                     fields.trap_bypass <= byte_data[5];
                     fields.comb_en     <= byte_data[4];
                     fields.ph1_tc      <= byte_data[3:2];
                     fields.xtal_cfg    <= byte_data[1:0];
                  end
                  SUB_W'(1): begin
                     fields.field_force <= byte_data[7:6];
                     fields.port_a      <= byte_data[5];
                     fields.port_b      <= byte_data[4];
                     fields.ph1_open    <= byte_data[3];
                     fields.std_force   <= byte_data[2:0];
                  end
                  SUB_W'(2): begin
                     fields.fast_sw_en  <= byte_data[7];
                     fields.search_tune <= byte_data[6];
                     fields.hue         <= byte_data[5:0];
                  end
                  SUB_W'(3): begin
                     fields.llc_en      <= byte_data[7];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/vdec_ctrl_lock.sv
module vdec_ctrl_lock #(
   parameter int SUB_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_stb,
   input  logic [SUB_W-1:0] wr_idx,
   input  logic             lock_lost,
   input  logic             cal_done,
   output logic             por_flag,
   output logic             cal_req
);

   localparam logic [SUB_W-1:0] XTAL_SUB = SUB_W'(0);
   localparam logic [SUB_W-1:0] GO_SUB   = SUB_W'(1);

   logic xtal_seen;
   logic go_start;

   assign go_start = wr_stb && por_flag && xtal_seen && (wr_idx == GO_SUB);

   always_ff @(posedge clk) begin
      if (rst) begin
         por_flag  <= 1'b1;
         xtal_seen <= 1'b0;
         cal_req   <= 1'b0;
      end else begin
         if (wr_stb && por_flag && wr_idx == XTAL_SUB)
            xtal_seen <= 1'b1;
         if (go_start)
            por_flag <= 1'b0;
         if (go_start || (lock_lost && !por_flag))
            cal_req <= 1'b1;
         else if (cal_done)
            cal_req <= 1'b0;
      end
   end

endmodule

// File: rtl/vdec_ctrl_if.sv
module vdec_ctrl_if
   import vdec_ctrl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] BASE_ADDR   = 7'b1000101,
   parameter int         SEL_BIT     = 1,
   parameter bit         ADDR_SEL_EN = 1'b1,
   parameter int         SUB_W       = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_sel,
   output logic       sda_pull,
   input  logic       st_field60,
   input  logic       st_yc_mode,
   input  logic       st_locked,
   input  logic       st_port_in,
   input  logic [2:0] st_std,
   input  logic       lock_lost,
   input  logic       cal_done,
   output logic [1:0] src_sel,
   output logic       trap_bypass,
   output logic       comb_en,
   output logic [1:0] ph1_tc,
   output logic [1:0] xtal_cfg,
   output logic [1:0] field_force,
   output logic       port_a,
   output logic       port_b,
   output logic       ph1_open,
   output logic [2:0] std_force,
   output logic       fast_sw_en,
   output logic       search_tune,
   output logic [5:0] hue_code,
   output logic [7:0] hue_step,
   output logic       llc_en,
   output logic       por_flag,
   output logic       cal_req
);

   localparam int         HUE_W   = 6;
   localparam logic [7:0] HUE_MID = 8'((1 << HUE_W) - 1);

   logic              scl_s;
   logic              byte_stb, byte_first;
   logic [BYTE_W-1:0] byte_data;
   logic [BYTE_W-1:0] status_byte;
   ctrl_fields_t      fields;
   logic              wr_stb;
   logic [SUB_W-1:0]  wr_idx;

   assign status_byte = {por_flag, st_field60, st_yc_mode, st_locked,
                         st_port_in, st_std};

   vdec_ctrl_phy #(
      .SYNC_STAGES (SYNC_STAGES),
      .BASE_ADDR   (BASE_ADDR),
      .SEL_BIT     (SEL_BIT),
      .ADDR_SEL_EN (ADDR_SEL_EN)
   ) i_phy (
      .clk        (clk),
      .rst        (rst),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .addr_sel   (addr_sel),
      .rd_byte    (status_byte),
      .sda_pull   (sda_pull),
      .scl_s      (scl_s),
      .byte_stb   (byte_stb),
      .byte_first (byte_first),
      .byte_data  (byte_data)
   );

   vdec_ctrl_regs #(.SUB_W(SUB_W)) i_regs (
      .clk        (clk),
      .rst        (rst),
      .byte_stb   (byte_stb),
      .byte_first (byte_first),
      .byte_data  (byte_data),
      .fields     (fields),
      .wr_stb     (wr_stb),
      .wr_idx     (wr_idx)
   );

   vdec_ctrl_lock #(.SUB_W(SUB_W)) i_lock (
      .clk       (clk),
      .rst       (rst),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx),
      .lock_lost (lock_lost),
      .cal_done  (cal_done),
      .por_flag  (por_flag),
      .cal_req   (cal_req)
   );

   assign src_sel     = fields.src_sel;
   assign trap_bypass = fields.trap_bypass;
   assign comb_en     = fields.comb_en;
   assign ph1_tc      = fields.ph1_tc;
   assign xtal_cfg    = fields.xtal_cfg;
   assign field_force = fields.field_force;
   assign port_a      = fields.port_a;
   assign port_b      = fields.port_b;
   assign ph1_open    = fields.ph1_open;
   assign std_force   = fields.std_force;
   assign fast_sw_en  = fields.fast_sw_en;
   assign search_tune = fields.search_tune;
   assign hue_code    = fields.hue;
   assign llc_en      = fields.llc_en;
   assign hue_step    = {1'b0, fields.hue, 1'b0} - HUE_MID;

endmodule

// File: rtl/vdec_ctrl_if_chk.sv
module vdec_ctrl_if_chk #(
   parameter int SUB_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             scl_s,
   input logic             sda_pull,
   input logic             por_flag,
   input logic             cal_req,
   input logic             cal_done,
   input logic             lock_lost,
   input logic             wr_stb,
   input logic [SUB_W-1:0] wr_idx,
   input logic [5:0]       hue_code
);

   // R2: the data line drive only changes to a pull while the clock is low
   assert_pull_edge_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(sda_pull) |-> (!$past(scl_s) || !sda_pull));

   // R4: a field changes only in the cycle its write lands
   assert_hue_write_only_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(hue_code) |-> wr_stb);

   // R7: the power-on flag falls only after a write to subaddress 01
   assert_por_clear_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(por_flag) |-> $past(wr_stb && wr_idx == SUB_W'(1)));

   // R8: no calibration request while the power-on flag is up
   assert_no_cal_in_por_R8: assert property (@(posedge clk) disable iff (rst)
      por_flag |-> !cal_req);

   // R8: a request appears only from startup or a lock loss
   assert_cal_source_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(cal_req) |-> ($fell(por_flag) || ($past(lock_lost) && $past(!por_flag))));

   // R9: done without a new request ends the calibration
   assert_cal_done_R9: assert property (@(posedge clk) disable iff (rst)
      (cal_req && cal_done && !lock_lost) |=> !cal_req);

   // R11: the power-on flag does not come back without reset
   assert_por_sticky_R11: assert property (@(posedge clk) disable iff (rst)
      !por_flag |=> !por_flag);

endmodule

bind vdec_ctrl_if vdec_ctrl_if_chk #(.SUB_W(SUB_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .scl_s     (scl_s),
   .sda_pull  (sda_pull),
   .por_flag  (por_flag),
   .cal_req   (cal_req),
   .cal_done  (cal_done),
   .lock_lost (lock_lost),
   .wr_stb    (wr_stb),
   .wr_idx    (wr_idx),
   .hue_code  (hue_code)
);

// File: tb/test_vdec_ctrl_if.sv
module test_vdec_ctrl_if;

   localparam int HALF = 12;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst = 1'b1;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       addr_sel = 1'b0;
   logic       st_field60 = 0, st_yc_mode = 0, st_locked = 0, st_port_in = 0;
   logic [2:0] st_std = '0;
   logic       lock_lost = 0, cal_done = 0;
   logic       sda_pull;
   logic [1:0] src_sel, ph1_tc, xtal_cfg, field_force;
   logic       trap_bypass, comb_en, port_a, port_b, ph1_open;
   logic [2:0] std_force;
   logic       fast_sw_en, search_tune, llc_en, por_flag, cal_req;
   logic [5:0] hue_code;
   logic [7:0] hue_step;
   wire        sda_bus = m_sda & ~sda_pull;

   vdec_ctrl_if i_vdec_ctrl_if (
      .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .addr_sel(addr_sel),
      .sda_pull(sda_pull), .st_field60(st_field60), .st_yc_mode(st_yc_mode),
      .st_locked(st_locked), .st_port_in(st_port_in), .st_std(st_std),
      .lock_lost(lock_lost), .cal_done(cal_done), .src_sel(src_sel),
      .trap_bypass(trap_bypass), .comb_en(comb_en), .ph1_tc(ph1_tc),
      .xtal_cfg(xtal_cfg), .field_force(field_force), .port_a(port_a),
      .port_b(port_b), .ph1_open(ph1_open), .std_force(std_force),
      .fast_sw_en(fast_sw_en), .search_tune(search_tune), .hue_code(hue_code),
      .hue_step(hue_step), .llc_en(llc_en), .por_flag(por_flag), .cal_req(cal_req)
   );

   int         n_chk = 0, n_fail = 0;
   bit         finished = 0;
   logic [7:0] mr [4];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [4];
   bit         exp_por = 1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1; m_scl = 1; wait_n(HALF);
      m_sda = 0; wait_n(HALF);
      m_scl = 0; wait_n(HALF);
   endtask

   task automatic bus_stop();
      m_sda = 0; wait_n(HALF);
      m_scl = 1; wait_n(HALF);
      m_sda = 1; wait_n(HALF);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wait_n(HALF);
      m_scl = 1; wait_n(HALF);
      m_scl = 0;
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1; wait_n(HALF);
      m_scl = 1; wait_n(HALF / 2);
      b = sda_bus; wait_n(HALF / 2);
      m_scl = 0;
   endtask

   task automatic send_byte(input logic [7:0] d, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      send_bit(!mack);
   endtask

   function automatic logic [6:0] cur_addr();
      return {5'b10001, addr_sel, 1'b1};
   endfunction

   // write: subaddress then n bytes of wbuf; updates the bench model
   task automatic bus_write(input logic [6:0] dev, input logic [7:0] sub,
                            input int n, output bit addr_ack, output bit all_ack);
      bit a;
      logic [3:0] p;
      bus_start();
      send_byte({dev, 1'b0}, addr_ack);
      all_ack = addr_ack;
      send_byte(sub, a); all_ack &= a;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], a);
         all_ack &= a;
      end
      bus_stop();
      if (dev == cur_addr()) begin
         p = sub[3:0];
         for (int k = 0; k < n; k++) begin
            if (p < 4) mr[p] = wbuf[k];
            p = p + 1'b1;
         end
      end
   endtask

   task automatic bus_read(input int n, output bit addr_ack);
      bus_start();
      send_byte({cur_addr(), 1'b1}, addr_ack);
      for (int k = 0; k < n; k++) recv_byte(rbuf[k], k < n - 1);
      bus_stop();
   endtask

   task automatic check_fields(input string req);
      chk({req, " src_sel"},     src_sel,     mr[0][7:6]);
      chk({req, " trap_bypass"}, trap_bypass, mr[0][5]);
      chk({req, " comb_en"},     comb_en,     mr[0][4]);
      chk({req, " ph1_tc"},      ph1_tc,      mr[0][3:2]);
      chk({req, " xtal_cfg"},    xtal_cfg,    mr[0][1:0]);
      chk({req, " field_force"}, field_force, mr[1][7:6]);
      chk({req, " port_a"},      port_a,      mr[1][5]);
      chk({req, " port_b"},      port_b,      mr[1][4]);
      chk({req, " ph1_open"},    ph1_open,    mr[1][3]);
      chk({req, " std_force"},   std_force,   mr[1][2:0]);
      chk({req, " fast_sw_en"},  fast_sw_en,  mr[2][7]);
      chk({req, " search_tune"}, search_tune, mr[2][6]);
      chk({req, " hue_code"},    hue_code,    mr[2][5:0]);
      chk({req, " llc_en"},      llc_en,      mr[3][7]);
   endtask

   task automatic pulse(input bit do_lost, input bit do_done);
      @(negedge clk);
      lock_lost = do_lost; cal_done = do_done;
      @(negedge clk);
      lock_lost = 0; cal_done = 0;
      wait_n(2);
   endtask

   task automatic t_reset();
      rst = 1; wait_n(5); rst = 0; wait_n(3);
      for (int i = 0; i < 4; i++) mr[i] = 8'h00;
      exp_por = 1;
      chk("R1 por_flag", por_flag, 1);
      chk("R1 cal_req", cal_req, 0);
      chk("R1 sda_pull", sda_pull, 0);
      check_fields("R1");
   endtask

   task automatic t_por_guard();
      bit aa, al;
      pulse(1, 0);
      chk("R8 lock_lost ignored in por", cal_req, 0);
      wbuf[0] = 8'h5A;
      bus_write(cur_addr(), 8'h01, 1, aa, al);
      chk("R3 ack 01 write", al, 1);
      chk("R7 early 01 keeps por", por_flag, 1);
      chk("R7 early 01 no cal", cal_req, 0);
      check_fields("R4 sub01");
   endtask

   task automatic t_address();
      bit aa, al;
      wbuf[0] = 8'hFF;
      bus_write(7'b1000111, 8'h02, 1, aa, al);
      chk("R2 alt addr nack when strap 0", aa, 0);
      check_fields("R2 no write");
      addr_sel = 1; wait_n(2);
      bus_write(7'b1000101, 8'h02, 1, aa, al);
      chk("R2 base addr nack when strap 1", aa, 0);
      check_fields("R2 no write");
      wbuf[0] = 8'h80;
      bus_write(7'b1000111, 8'h03, 1, aa, al);
      chk("R2 alt addr ack", al, 1);
      chk("R2 llc_en via alt addr", llc_en, 1);
      addr_sel = 0; wait_n(2);
   endtask

   task automatic t_startup();
      bit aa, al;
      wbuf[0] = 8'hA5;
      bus_write(cur_addr(), 8'h00, 1, aa, al);
      chk("R7 por after 00", por_flag, 1);
      check_fields("R4 sub00");
      wbuf[0] = 8'h3C;
      bus_write(cur_addr(), 8'h01, 1, aa, al);
      exp_por = 0;
      chk("R7 por cleared", por_flag, 0);
      chk("R7 cal started", cal_req, 1);
      check_fields("R4 sub01");
      pulse(0, 1);
      chk("R9 done clears cal", cal_req, 0);
   endtask

   task automatic t_autoinc();
      bit aa, al;
      wbuf[0] = 8'h5B; wbuf[1] = 8'hC7; wbuf[2] = 8'h9E; wbuf[3] = 8'h80;
      bus_write(cur_addr(), 8'h00, 4, aa, al);
      chk("R3 ack burst", al, 1);
      check_fields("R3 burst");
      wbuf[0] = 8'h11; wbuf[1] = 8'h6E;
      bus_write(cur_addr(), 8'h0F, 2, aa, al);
      chk("R5 ack 0F", al, 1);
      chk("R3 wrap to 00", {src_sel, trap_bypass, comb_en, ph1_tc, xtal_cfg}, 8'h6E);
      check_fields("R5 wrap");
      wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
      bus_write(cur_addr(), 8'h05, 3, aa, al);
      chk("R5 ack 05..07", al, 1);
      check_fields("R5 discard");
      chk("R11 no cal on rewrite", cal_req, 0);
      chk("R11 por stays 0", por_flag, 0);
   endtask

   task automatic t_read();
      bit aa, al;
      logic [7:0] exp;
      st_field60 = 1; st_yc_mode = 0; st_locked = 1; st_port_in = 1; st_std = 3'b101;
      wait_n(2);
      exp = {exp_por, st_field60, st_yc_mode, st_locked, st_port_in, st_std};
      bus_read(2, aa);
      chk("R6 read ack", aa, 1);
      chk("R6 status byte 0", rbuf[0], exp);
      chk("R6 status byte 1", rbuf[1], exp);
      bus_write(cur_addr(), 8'h02, 0, aa, al);
      st_field60 = 0; st_yc_mode = 1; st_locked = 0; st_port_in = 0; st_std = 3'b010;
      wait_n(2);
      exp = {exp_por, st_field60, st_yc_mode, st_locked, st_port_in, st_std};
      bus_read(1, aa);
      chk("R6 status at ptr 02", rbuf[0], exp);
      chk("R6 line released", sda_pull, 0);
   endtask

   task automatic t_lock();
      pulse(1, 0);
      chk("R8 lock_lost raises cal", cal_req, 1);
      pulse(1, 1);
      chk("R9 new request wins over done", cal_req, 1);
      pulse(0, 1);
      chk("R9 done clears", cal_req, 0);
   endtask

   task automatic t_hue();
      bit aa, al;
      int codes [3] = '{0, 63, 32};
      foreach (codes[i]) begin
         wbuf[0] = {2'b00, 6'(codes[i])};
         bus_write(cur_addr(), 8'h02, 1, aa, al);
         chk("R10 hue_step", $signed(hue_step), 2 * codes[i] - 63);
      end
      check_fields("R10 fields");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_por_guard();
      t_address();
      t_startup();
      t_autoinc();
      t_read();
      t_lock();
      t_hue();
      t_reset();
      chk("R11 por only by reset", por_flag, 1);
      finish_run();
   end

endmodule